// File: doc/BRIEF.md
# Multicycle 16-bit RISC Processor Core

This core runs a small load/store instruction set on a 16-bit datapath. Every register, address and data word is 16 bits wide. There is one memory port, shared by instruction fetches and by data loads and stores. Memory is byte-addressed and holds 16-bit words. Program code starts at address 0 and data RAM starts at address 64.

A five-state controller steps each instruction through these states: fetch, decode/register read, execute, memory access and write-back. Each instruction skips the states it does not need, so different instruction classes take different numbers of clock cycles. The core holds eight general registers; register 0 always reads as zero. A call instruction stores its return address in register 7, and a register-indirect jump through register 7 returns from the subroutine.

The combinational ALU result is always visible on a debug output. The memory model is not part of the core: it belongs to the surrounding system.

Top module: `mcpu16`

## Requirements
- R1: When `rst` is high at a rising clock edge, the PC and the controller return to the fetch state with PC = 0. The first cycle after reset drives `mem_addr` = 0.
- R2: A fetch drives the PC onto `mem_addr` and latches `mem_rdata` as the instruction. The PC then advances by 2.
- R3: Instruction fields are: op = [15:13], rs = [12:10], rt = [9:7], rd = [6:4], fn = [3:0], imm7 = [6:0] (signed).
  - op 0 is register-register: rd = rs ⊕ rt.
  - fn 0 is add, 1 is sub, 2 is and, 3 is or, 4 is signed set-less-than.
- R4: op 1 (addi) writes rt = rs + sign-extended imm7, so negative immediates work.
- R5: Register 0 reads as zero, even after an instruction names it as a destination.
- R6: op 2 (beq) compares rs and rt. When they are equal, PC = PC+2 + (imm7 << 1); otherwise execution falls through.
- R7: op 3 (j) loads PC = {PC[15:14], ir[12:0], 0}.
- R8: op 4 (jal) jumps like op 3 and writes PC+2 into register 7. op 0 with fn 8 (jr) loads PC from rs.
- R9: op 5 (lw) loads rt from address rs + sign-extended imm7. op 6 (sw) stores rt to that address.
- R10: Cycle counts are fixed: beq, j, jal and jr take 3 cycles; register-register and addi take 4; sw takes 4; lw takes 5.
- R11: `mem_we` is high only in the memory-access cycle of a store, exactly once per store.
- R12: `alu_dbg` always carries the ALU result. During a store's memory cycle it equals the effective address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 16 | Shared memory byte address |
| mem_wdata | output | 16 | Store data |
| mem_rdata | input | 16 | Word read from `mem_addr` (combinational) |
| mem_we | output | 1 | Write enable for the store cycle |
| alu_dbg | output | 16 | Live ALU result for debugging |

## Verification
The bench builds short programs in memory and runs each one from reset to a sentinel store at address 126. It counts the cycles to that store and the writes made on the way. A wrong state sequence for any instruction class therefore shifts the count. A store that writes twice, or an enable that leaks into another class, changes the write total.

ALU operands are swept over signed values at the edges of the 7-bit immediate range:
- A design that zero-extends the immediate gives wrong sums for negative operands.
- A design that compares unsigned gives a wrong set-less-than result for negative operands.

A counted loop is run for trip counts from zero upward. An off-by-one in the branch offset changes the stored count or hangs the program. A subroutine call stores its link register, so a wrong return address is visible.

A swap program with negative load/store offsets exposes a base-plus-offset address that is formed wrongly. It also exposes a load result that is written back a cycle too early.

// File: rtl/mcpu16.sv
module mcpu16 #(
  parameter int XLEN = 16,
  parameter int NREG = 8
) (
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  input  logic [XLEN-1:0] mem_rdata,
  output logic            mem_we,
  output logic [XLEN-1:0] alu_dbg
);
  localparam logic [2:0] OP_R = 3'd0, OP_ADDI = 3'd1, OP_BEQ = 3'd2, OP_J = 3'd3,
                         OP_JAL = 3'd4, OP_LW = 3'd5, OP_SW = 3'd6;
  localparam logic [3:0] FN_ADD = 4'd0, FN_SUB = 4'd1, FN_AND = 4'd2, FN_OR = 4'd3,
                         FN_SLT = 4'd4, FN_JR = 4'd8;
  localparam logic [2:0] LINK = 3'd7;

  typedef enum logic [2:0] {S_FETCH, S_DEC, S_EXEC, S_MEM, S_WB} st_t;

  st_t             st;
  logic [XLEN-1:0] pc, ir, mdr, ra, rb, alu_q;
  logic [XLEN-1:0] rf [NREG];

  wire [2:0]      op  = ir[15:13];
  wire [2:0]      rs  = ir[12:10];
  wire [2:0]      rt  = ir[9:7];
  wire [2:0]      rd  = ir[6:4];
  wire [3:0]      fn  = ir[3:0];
  wire [XLEN-1:0] imm = {{(XLEN-7){ir[6]}}, ir[6:0]};

  wire [XLEN-1:0] opb  = (op == OP_R) ? rb : imm;
  wire [3:0]      fsel = (op == OP_R) ? fn : FN_ADD;
  logic [XLEN-1:0] alu_res;

  always_comb begin
    case (fsel)
      FN_SUB:  alu_res = ra - opb;
      FN_AND:  alu_res = ra & opb;
      FN_OR:   alu_res = ra | opb;
      FN_SLT:  alu_res = ($signed(ra) < $signed(opb)) ? {{(XLEN-1){1'b0}}, 1'b1} : '0;
      default: alu_res = ra + opb;
    endcase
  end

  assign alu_dbg   = alu_res;
  assign mem_addr  = (st == S_FETCH) ? pc : alu_q;
  assign mem_wdata = rb;
  assign mem_we    = (st == S_MEM) && (op == OP_SW);

  wire [2:0]      wb_dst = (op == OP_R) ? rd : rt;
  wire [XLEN-1:0] wb_val = (op == OP_LW) ? mdr : alu_q;
  wire [XLEN-1:0] jtgt   = {pc[XLEN-1:14], ir[12:0], 1'b0};

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= S_FETCH;
      pc    <= '0;
      ir    <= '0;
      mdr   <= '0;
      ra    <= '0;
      rb    <= '0;
      alu_q <= '0;
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else begin
      case (st)
        S_FETCH: begin
          ir <= mem_rdata;
          pc <= pc + XLEN'(2);
          st <= S_DEC;
        end
        S_DEC: begin
          ra <= (rs == 3'd0) ? '0 : rf[rs];
          rb <= (rt == 3'd0) ? '0 : rf[rt];
          st <= S_EXEC;
        end
        S_EXEC: begin
          alu_q <= alu_res;
          st    <= S_FETCH;
          case (op)
            OP_R:        if (fn == FN_JR) pc <= ra; else st <= S_WB;
            OP_ADDI:     st <= S_WB;
            OP_LW, OP_SW: st <= S_MEM;
            OP_BEQ:      if (ra == rb) pc <= pc + {imm[XLEN-2:0], 1'b0};
            OP_J:        pc <= jtgt;
            OP_JAL: begin
              pc       <= jtgt;
              rf[LINK] <= pc;
            end
            default: ;
          endcase
        end
        S_MEM: begin
          if (op == OP_LW) begin
            mdr <= mem_rdata;
            st  <= S_WB;
          end else begin
            st <= S_FETCH;
          end
        end
        default: begin
          if (wb_dst != 3'd0) rf[wb_dst] <= wb_val;
          st <= S_FETCH;
        end
      endcase
    end
  end

  p_reset_pc_r1: assert property (@(posedge clk) rst |=> (pc == '0 && st == S_FETCH));
  p_fetch_step_r2: assert property (@(posedge clk) disable iff (rst)
    (st == S_FETCH) |=> (pc == $past(pc) + XLEN'(2) && st == S_DEC));
  p_zero_read_r5: assert property (@(posedge clk) disable iff (rst)
    (st == S_DEC && rs == 3'd0) |=> (ra == '0));
  p_beq_fall_r6: assert property (@(posedge clk) disable iff (rst)
    (st == S_EXEC && op == OP_BEQ && ra != rb) |=> (pc == $past(pc)));
  p_link_r8: assert property (@(posedge clk) disable iff (rst)
    (st == S_EXEC && op == OP_JAL) |=> (rf[LINK] == $past(pc)));
  p_load_len_r10: assert property (@(posedge clk) disable iff (rst)
    (st == S_MEM && !mem_we) |=> (st == S_WB));
  p_we_once_r11: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> (!mem_we && st == S_FETCH));
  p_dbg_addr_r12: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (alu_dbg == mem_addr));
endmodule

// File: tb/mcpu16_bench.sv
module mcpu16_bench;
  localparam int PER = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] mem_addr, mem_wdata, mem_rdata, alu_dbg;
  logic        mem_we;
  logic [15:0] mem [0:127];
  int          n_chk = 0, n_bad = 0, wp = 0;

  always #(PER/2) clk = ~clk;

  mcpu16 u_mcpu16 (.clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
                   .mem_rdata(mem_rdata), .mem_we(mem_we), .alu_dbg(alu_dbg));

  assign mem_rdata = mem[mem_addr[7:1]];
  always @(posedge clk) if (mem_we) mem[mem_addr[7:1]] <= mem_wdata;

  function automatic logic [15:0] enc_r(int s, int t, int d, int f);
    return {3'd0, 3'(s), 3'(t), 3'(d), 4'(f)};
  endfunction
  function automatic logic [15:0] enc_i(int op, int s, int t, int imm);
    return {3'(op), 3'(s), 3'(t), 7'(imm)};
  endfunction
  function automatic logic [15:0] enc_j(int op, int tgt);
    logic [15:0] b = 16'(tgt);
    return {3'(op), b[13:1]};
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < 128; i++) mem[i] = 16'hDEAD;
    wp = 0;
  endtask
  task automatic emit(logic [15:0] w);
    mem[wp] = w;
    wp++;
  endtask

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(int exp_cyc, int exp_wr);
    int cyc = 0, wr = 0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk("R1 first fetch address", mem_addr, 16'd0);
    while (!(mem_we && mem_addr == 16'd126) && cyc < 3000) begin
      if (mem_we) wr++;
      @(negedge clk);
      cyc++;
    end
    wr++;
    chk("R10 cycles to sentinel", 16'(cyc), 16'(exp_cyc));
    chk("R11 store count", 16'(wr), 16'(exp_wr));
    chk("R12 alu_dbg on store", alu_dbg, 16'd126);
    @(negedge clk);
  endtask

  initial begin
    #(PER * 190000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int vals[8] = '{0, 1, -1, 5, -64, 63, -7, 22};
    logic [15:0] a16, b16;

    // R3 R4 R5 R9 R12: ALU sweep over signed operand pairs
    foreach (vals[i]) foreach (vals[j]) begin
      clear_mem();
      emit(enc_i(1, 0, 1, vals[i]));
      emit(enc_i(1, 0, 2, vals[j]));
      emit(enc_i(1, 0, 4, 63));
      emit(enc_i(1, 4, 4, 1));
      for (int f = 0; f < 5; f++) begin
        emit(enc_r(1, 2, 3, f));
        emit(enc_i(6, 4, 3, 2 * f));
      end
      emit(enc_r(1, 2, 0, 0));
      emit(enc_i(6, 4, 0, 10));
      emit(enc_i(1, 1, 5, -2));
      emit(enc_i(6, 4, 5, 12));
      emit(enc_i(6, 4, 0, 62));
      emit(enc_j(3, 2 * wp));
      run(75, 8);
      a16 = 16'(vals[i]);
      b16 = 16'(vals[j]);
      chk("R3 add", mem[32], a16 + b16);
      chk("R3 sub", mem[33], a16 - b16);
      chk("R3 and", mem[34], a16 & b16);
      chk("R3 or",  mem[35], a16 | b16);
      chk("R3 slt", mem[36], (vals[i] < vals[j]) ? 16'd1 : 16'd0);
      chk("R5 zero register", mem[37], 16'd0);
      chk("R4 addi negative", mem[38], a16 - 16'd2);
    end

    // R6 R7 R8: counted loop with beq/j, then call and return through register 7
    for (int n = 0; n <= 10; n++) begin
      clear_mem();
      emit(enc_r(0, 0, 1, 0));
      emit(enc_i(1, 0, 2, n));
      emit(enc_i(1, 0, 4, 63));
      emit(enc_i(1, 4, 4, 1));
      emit(enc_i(2, 1, 2, 2));
      emit(enc_i(1, 1, 1, 1));
      emit(enc_j(3, 8));
      emit(enc_i(6, 4, 1, 0));
      emit(enc_j(4, 26));
      emit(enc_i(6, 4, 6, 4));
      emit(enc_i(6, 4, 7, 6));
      emit(enc_i(6, 4, 0, 62));
      emit(enc_j(3, 24));
      emit(enc_i(1, 0, 6, -5));
      emit(enc_r(7, 0, 0, 8));
      run(44 + 10 * n, 4);
      chk("R6 loop trip count", mem[32], 16'(n));
      chk("R8 subroutine result", mem[34], 16'hFFFB);
      chk("R8 link register", mem[35], 16'd18);
    end

    // R9: swap through memory with positive and negative offsets
    for (int k = 0; k < 4; k++) begin
      int a = vals[k + 2], b = vals[7 - k];
      clear_mem();
      emit(enc_i(1, 0, 1, a));
      emit(enc_i(1, 0, 2, b));
      emit(enc_i(1, 0, 3, 63));
      emit(enc_i(1, 3, 3, 1));
      emit(enc_i(6, 3, 1, 2));
      emit(enc_i(6, 3, 2, 4));
      emit(enc_i(5, 3, 2, 2));
      emit(enc_i(5, 3, 1, 4));
      emit(enc_i(6, 3, 1, 8));
      emit(enc_i(6, 3, 2, 10));
      emit(enc_i(1, 3, 5, 20));
      emit(enc_i(6, 5, 1, -8));
      emit(enc_i(6, 5, 2, -6));
      emit(enc_i(6, 3, 0, 62));
      emit(enc_j(3, 2 * wp));
      run(57, 7);
      chk("R9 store a",           mem[33], 16'(a));
      chk("R9 store b",           mem[34], 16'(b));
      chk("R9 swapped load b",    mem[36], 16'(b));
      chk("R9 swapped load a",    mem[37], 16'(a));
      chk("R9 negative offset b", mem[38], 16'(b));
      chk("R9 negative offset a", mem[39], 16'(a));
      chk("R2 code untouched",    mem[0], enc_i(1, 0, 1, a));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule